// File: doc/BRIEF.md
# Synchronous Differential Clock Stop Controller

This block produces a set of differential clock output pairs, each a true and a complement signal at half the source clock rate. An active-low stop request can park some of the pairs while the rest keep running. A per-pair mask bit marks each pair as stoppable or free running. Stoppable pairs respond to the request; the other pairs ignore it.

The request is asynchronous and is resynchronized on the rising edges of the internal complement phase, which are the source edges where the true output falls. A stop takes effect only after the request has been seen low on two consecutive such edges. A parked pair holds its true output high and its complement output low. It also drops a complement drive-enable, so that the pad logic can release the complement line.

Every stop and every restart happens on a source edge where the true output would rise anyway. The last pulse before a stop and the first pulse after a restart therefore have full width. After the request is released, parked pairs resume within two output periods.

Top module: `cks_stop_ctrl`

## Requirements
- R1: While reset is low, every pair drives true 0, complement 1 and drive-enable 1, and the request synchronizer is cleared. After reset, no pair parks unless a request arrives. A reset applied while pairs are parked brings every drive-enable back to 1.
- R2: A running pair toggles its true output on every source clock edge, so the output period is two source cycles. While drive-enable is 1, the complement is the inverse of the true output.
- R3: A pair whose mask bit is 0 keeps drive-enable at 1 and keeps toggling, whatever the request does.
- R4: The request is sampled only on source edges where the true phase falls. A low level that covers just one such edge never parks any pair.
- R5: Suppose the request is driven low between source edges k-1 and k and then held. Every stoppable pair still has drive-enable 1 after edge k+2, and is parked after edge k+4.
- R6: A parked pair drives true 1, complement 0 and drive-enable 0.
- R7: Suppose the request is driven high between edges k-1 and k. Every drive-enable is 1 after edge k+2, and every stoppable pair's true output has gone low after edge k+2 or after edge k+3.
- R8: Every low interval of a true output lasts exactly one source cycle. Every high interval lasts exactly one source cycle unless the pair was parked during it. There are no shortened or stretched pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Source clock, twice the output frequency |
| rst_n | input | 1 | Synchronous active-low reset |
| stop_req_n | input | 1 | Asynchronous active-low stop request |
| stoppable_mask | input | NUM_PAIRS | Bit i set: pair i obeys the request |
| clk_t_o | output | NUM_PAIRS | True output of each pair |
| clk_c_o | output | NUM_PAIRS | Complement output of each pair |
| clk_c_oe | output | NUM_PAIRS | Complement drive-enable, 0 while parked |

## Verification
A wrong synchronizer stage or a wrong park-slot decision shows up at the ports as a drive-enable edge one or two source cycles away from the window stated in R5 or R7. It is caught at the first stop or release that follows. A fault in the phase gating shows up as a low interval of two cycles, or as a running high interval of two cycles, on the very next pulse. A pulse monitor checks every pair on every cycle for these. The sweep covers all sixteen masks of a four-pair instance at both request phases, so a fault tied to one pair or one phase is also reached.

// File: rtl/cks_pkg.sv
// Shared types for the differential clock stop controller.
package cks_pkg;
    // Registered drive state of one output pair.
    typedef struct packed {
        logic t;   // true output
        logic c;   // complement output
        logic en;  // complement drive-enable
    } cks_drive_t;
endpackage

// File: rtl/cks_phase_gen.sv
// Output phase generator.
// Toggles once per source clock, so every pair runs at half the source rate.
// phase_q == 1 means the next edge is a falling edge of the true output,
// which is a rising edge of the complement phase.
// Assumes a synchronous active-low reset.
module cks_phase_gen (
    input  logic clk,
    input  logic rst_n,
    output logic phase_q
);
    // Free-running divide-by-two toggle.
    always_ff @(posedge clk) begin
        if (!rst_n) phase_q <= 1'b0;
        else        phase_q <= ~phase_q;
    end
endmodule

// File: rtl/cks_req_sync.sv
// Stop request synchronizer.
// Shifts the inverted active-low request through STAGES registers.
// The registers advance only on complement-phase rising edges.
// stop_full: every stage has seen the request (used to enter the parked state).
// stop_live: the newest stage still sees it (used to hold the parked state).
// Assumes STAGES >= 2.
module cks_req_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic phase_q,
    input  logic stop_req_n,
    output logic stop_full,
    output logic stop_live
);
    localparam int TOP = STAGES - 1;

    logic [TOP:0] st_q;

    // Advance the chain on complement rising edges only.
    always_ff @(posedge clk) begin
        if (!rst_n)       st_q <= '0;
        else if (phase_q) st_q <= {st_q[TOP-1:0], ~stop_req_n};
    end

    assign stop_full = &st_q;
    assign stop_live = st_q[0];

    // R4
    sync_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !phase_q |=> $stable(st_q));

    // R4
    sync_depth_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q[TOP]) |-> $past(st_q[TOP-1]));
endmodule

// File: rtl/cks_pair_gate.sv
// Gate for one output pair.
// Decides whether the pair is parked, on park-slot edges only. These are the
// edges where the true output rises anyway, so the gating never cuts a pulse.
// A parked pair holds true high and complement low, with drive-enable off.
// Assumes phase_q comes from cks_phase_gen and stop_full/stop_live from
// cks_req_sync.
module cks_pair_gate
    import cks_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       phase_q,
    input  logic       stoppable,
    input  logic       stop_full,
    input  logic       stop_live,
    output cks_drive_t drive_o
);
    logic stopped_q;
    logic stopped_nxt;
    logic park_slot;
    logic t_q;
    logic c_q;

    assign park_slot = ~phase_q;

    // Next park state: it can change only on a park slot.
    always_comb begin
        stopped_nxt = stopped_q;
        if (park_slot)
            stopped_nxt = stoppable & stop_live & (stop_full | stopped_q);
    end

    // Park state register.
    always_ff @(posedge clk) begin
        if (!rst_n) stopped_q <= 1'b0;
        else        stopped_q <= stopped_nxt;
    end

    // Registered outputs: follow the phase, or hold the parked levels.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            t_q <= 1'b0;
            c_q <= 1'b1;
        end else begin
            t_q <= ~phase_q | stopped_nxt;
            c_q <= phase_q & ~stopped_nxt;
        end
    end

    assign drive_o = '{t: t_q, c: c_q, en: ~stopped_q};

    // R6
    park_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stopped_q |-> (t_q && !c_q));

    // R2
    comp_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !stopped_q |-> (t_q != c_q));

    // R8
    low_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(t_q) |=> t_q);

    // R3
    free_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!stoppable && !$past(stoppable) && !$past(stoppable, 2)) |-> !stopped_q);

    // R5
    park_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stopped_q) |-> $past(stop_full));

    // R7
    release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stopped_q && !stop_live && !phase_q) |=> !stopped_q);
endmodule

// File: rtl/cks_stop_ctrl.sv
// Synchronous differential clock stop controller (top).
// One phase generator and one request synchronizer are shared by all
// NUM_PAIRS pair gates. Each pair gate has its own stoppable mask bit.
// Assumes clk is the source clock and rst_n a synchronous active-low reset.
module cks_stop_ctrl
    import cks_pkg::*;
#(
    parameter int NUM_PAIRS   = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 stop_req_n,
    input  logic [NUM_PAIRS-1:0] stoppable_mask,
    output logic [NUM_PAIRS-1:0] clk_t_o,
    output logic [NUM_PAIRS-1:0] clk_c_o,
    output logic [NUM_PAIRS-1:0] clk_c_oe
);
    localparam int LAST_PAIR = NUM_PAIRS - 1;

    logic phase_q;
    logic stop_full;
    logic stop_live;
    cks_drive_t drive [LAST_PAIR:0];

    cks_phase_gen u_phase (
        .clk     (clk),
        .rst_n   (rst_n),
        .phase_q (phase_q)
    );

    cks_req_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk        (clk),
        .rst_n      (rst_n),
        .phase_q    (phase_q),
        .stop_req_n (stop_req_n),
        .stop_full  (stop_full),
        .stop_live  (stop_live)
    );

    // One gate per output pair.
    for (genvar i = 0; i <= LAST_PAIR; i++) begin : g_pair
        cks_pair_gate u_gate (
            .clk       (clk),
            .rst_n     (rst_n),
            .phase_q   (phase_q),
            .stoppable (stoppable_mask[i]),
            .stop_full (stop_full),
            .stop_live (stop_live),
            .drive_o   (drive[i])
        );
        assign clk_t_o[i]  = drive[i].t;
        assign clk_c_o[i]  = drive[i].c;
        assign clk_c_oe[i] = drive[i].en;
    end
endmodule

// File: tb/cks_stop_ctrl_tb_top.sv
module cks_stop_ctrl_tb_top;
    localparam int NP = 4;
    localparam logic [NP-1:0] ALL1 = '1;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic          rst_n;
    logic          stop_req_n;
    logic [NP-1:0] mask;
    logic [NP-1:0] t_o, c_o, oe;

    int  checks = 0;
    int  fails  = 0;
    int  cyc    = 0;
    bit  done   = 0;

    cks_stop_ctrl #(.NUM_PAIRS(NP), .SYNC_STAGES(2)) dut_i (
        .clk            (clk),
        .rst_n          (rst_n),
        .stop_req_n     (stop_req_n),
        .stoppable_mask (mask),
        .clk_t_o        (t_o),
        .clk_c_o        (c_o),
        .clk_c_oe       (oe)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Wait n rising edges, then move to the following falling edge.
    task automatic after_edges(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic report;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    endtask

    // Watchdog.
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !done) begin
            fails++;
            $display("FAIL watchdog cycles actual=%0d expected=%0d", cyc, 150000);
            report();
            $finish;
        end
    end

    // Pulse monitor: pulse widths (R8) and pair levels (R2, R6), every cycle.
    logic prev_t [NP];
    int   run    [NP];
    bit   valid  [NP];
    bit   parked [NP];
    always @(negedge clk) begin
        for (int i = 0; i < NP; i++) begin
            if (!rst_n) begin
                valid[i]  = 0;
                run[i]    = 0;
                parked[i] = 0;
                prev_t[i] = t_o[i];
            end else begin
                if (oe[i]) chk(c_o[i] == ~t_o[i], "R2", "complement level", c_o[i], ~t_o[i]);
                else       chk(t_o[i] && !c_o[i], "R6", "parked levels t,c", {t_o[i], c_o[i]}, 2);
                if (t_o[i] != prev_t[i]) begin
                    if (valid[i]) begin
                        if (!prev_t[i])
                            chk(run[i] == 1, "R8", "low interval", run[i], 1);
                        else if (!parked[i])
                            chk(run[i] == 1, "R8", "high interval", run[i], 1);
                    end
                    valid[i]  = 1;
                    run[i]    = 1;
                    parked[i] = !oe[i];
                end else begin
                    run[i]++;
                    if (!oe[i]) parked[i] = 1;
                end
                prev_t[i] = t_o[i];
            end
        end
    end

    initial begin
        logic [NP-1:0] low_seen;
        rst_n      = 1'b0;
        stop_req_n = 1'b1;
        mask       = '0;
        after_edges(3);
        // R1: levels while reset is low
        chk(t_o == '0,  "R1", "true in reset", t_o, 0);
        chk(c_o == ALL1, "R1", "complement in reset", c_o, ALL1);
        chk(oe == ALL1,  "R1", "enable in reset", oe, ALL1);
        mask  = ALL1;
        rst_n = 1'b1;
        after_edges(6);
        // R1: no park without a request
        chk(oe == ALL1, "R1", "enable after reset", oe, ALL1);

        // R4: a low level that covers one sampling edge is filtered, at both phases
        for (int off = 0; off < 2; off++) begin
            repeat (off + 1) @(negedge clk);
            stop_req_n = 1'b0;
            @(negedge clk);
            @(negedge clk);
            stop_req_n = 1'b1;
            for (int s = 0; s < 8; s++) begin
                @(negedge clk);
                chk(oe == ALL1, "R4", "enable after short request", oe, ALL1);
            end
        end

        // R3 R5 R6 R7: sweep every mask at both request phases
        for (int m = 0; m < (1 << NP); m++) begin
            for (int off = 0; off < 2; off++) begin
                mask = m[NP-1:0];
                repeat (off + 1) @(negedge clk);
                stop_req_n = 1'b0;
                after_edges(3);
                chk(oe == ALL1, "R5", "enable after edge k+2", oe, ALL1);
                after_edges(2);
                chk(oe == ~mask, "R5", "enable after edge k+4", oe, ~mask);
                chk((t_o & mask) == mask, "R6", "parked true", t_o & mask, mask);
                chk((c_o & mask) == '0, "R6", "parked complement", c_o & mask, 0);
                for (int s = 0; s < 6; s++) begin
                    @(negedge clk);
                    chk((oe & ~mask) == ~mask, "R3", "free-running enable", oe & ~mask, ~mask);
                    chk((oe & mask) == '0, "R6", "parked enable", oe & mask, 0);
                end
                repeat (m % 2 + off) @(negedge clk);
                stop_req_n = 1'b1;
                after_edges(3);
                chk(oe == ALL1, "R7", "enable after release edge k+2", oe, ALL1);
                low_seen = ~t_o;
                after_edges(1);
                low_seen = low_seen | ~t_o;
                chk(low_seen == ALL1, "R7", "true fell by edge k+3", low_seen, ALL1);
                after_edges(3);
            end
        end

        // R1: reset while parked clears the synchronizer
        mask = ALL1;
        stop_req_n = 1'b0;
        after_edges(8);
        chk(oe == '0, "R1", "parked before reset", oe, 0);
        rst_n = 1'b0;
        stop_req_n = 1'b1;
        after_edges(1);
        chk(oe == ALL1, "R1", "enable in reset from park", oe, ALL1);
        chk(t_o == '0,  "R1", "true in reset from park", t_o, 0);
        rst_n = 1'b1;
        for (int s = 0; s < 6; s++) begin
            @(negedge clk);
            chk(oe == ALL1, "R1", "enable after reset from park", oe, ALL1);
        end

        done = 1;
        report();
        $finish;
    end
endmodule